// File: doc/BRIEF.md
# SPI Flash Direct-Read Engine

This block serves memory-mapped host reads from a serial NOR flash. Each host request names a DWord address, a DWord count and a byte-enable mask for the first DWord. From the mask and the count the engine picks a flash start byte and a byte count. It then runs one read frame as an SPI mode-0 master. The frame is opcode 03h, a 24-bit address and the data bytes, all under a single chip-select assertion. Completion data goes back to the host one DWord at a time, as soon as each DWord is filled.

After reset the engine does not accept host reads. It keeps sending the status-read opcode 05h, with chip select released between polls, until bit 0 of the returned status byte is clear. A request presented while a poll or a transfer is in progress is held off by a low ready signal and waits in place until the engine is idle again.

Top module: `spi_flash_dread`

## Requirements
- R1: After reset, `req_ready_o` stays low while the engine polls the flash. Each poll is a separate chip-select frame: opcode 05h, then one status byte read back. Polling stops at the first status byte whose bit 0 is 0, and only then does `req_ready_o` go high.
- R2: A one-DWord request with byte enables 0000 starts no SPI frame. It returns one completion with data 0xFFFFFFFF, last set and error clear.
- R3: A one-DWord request with contiguous enables (0001, 0010, 0100, 1000, 0011, 0110, 1100, 0111, 1110, 1111; bit 3 is the highest byte lane) reads exactly the enabled bytes. The read starts at DWord address ×4 plus the index of the lowest set enable bit.
- R4: A one-DWord request with a gapped enable mask (0101, 1001, 1010, 1011, 1101) reads 4 bytes, starting at the DWord-aligned address.
- R5: A request of N>1 DWords whose first enables are 1000, 1100, 1110 or 1111 reads 4·(N−1) plus the number of set enable bits. The read starts at the lowest enabled byte.
- R6: A request of N>1 DWords with any other nonzero first enable mask reads 4·N bytes, starting at the DWord-aligned address.
- R7: A request of N>1 DWords with first enables 0000 starts no SPI frame. It returns one completion with `rsp_err_o`, last set and data 0xFFFFFFFF.
- R8: A read frame holds `spi_cs_no` low throughout. It sends 03h, then the 24-bit start address MSB first, then clocks exactly the computed number of data bytes. Data leaves on `spi_mosi_o` while SCK is low and is sampled from `spi_miso_i` at the high phase (mode 0).
- R9: Read bytes are packed little-endian. Byte address bits [1:0] select the lane, and lanes not read return 0xFF. Each request gives exactly N completions, with `rsp_last_o` on the final one only. A completion is issued as soon as its DWord is filled, while the frame is still in progress.
- R10: While a poll or a read is in progress, `req_ready_o` is low. A request held valid is accepted only after the current access has ended and chip select has been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host read request present |
| req_ready_o | output | 1 | Engine idle; request accepted when both high |
| req_dw_addr_i | input | 22 | DWord address of the first DWord |
| req_ndw_i | input | 5 | Number of DWords, 1 to 16 |
| req_first_be_i | input | 4 | Byte enables of the first DWord, bit 3 = highest lane |
| rsp_valid_o | output | 1 | Completion DWord valid, one cycle |
| rsp_data_o | output | 32 | Completion data, little-endian |
| rsp_last_o | output | 1 | Final completion of the request |
| rsp_err_o | output | 1 | Illegal request flag |
| spi_cs_no | output | 1 | Flash chip select, active low |
| spi_sck_o | output | 1 | SPI clock, idles low |
| spi_mosi_o | output | 1 | Serial data to flash |
| spi_miso_i | input | 1 | Serial data from flash |

## Verification
The assertions assume that a host keeps `req_valid_i` and the request fields unchanged until `req_ready_o` accepts them, and that `req_ndw_i` always lies between 1 and 16. The bench meets both: it sets a request at a falling edge, changes nothing until the cycle of acceptance, and draws every count from that range. The flash model changes `spi_miso_i` only on falling SCK edges, so the sampling instant asserted for mode 0 always sees settled data.

// File: rtl/spi_dr_pkg.sv
package spi_dr_pkg;
  localparam int unsigned FLASH_AW = 24;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_STATUS = 8'h05;

  typedef enum logic [2:0] {
    ST_POLL_GAP,
    ST_POLL_CMD,
    ST_POLL_RD,
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DATA,
    ST_END
  } dr_state_e;
endpackage

// File: rtl/spi_dr_plan.sv
module spi_dr_plan
  import spi_dr_pkg::*;
#(
  parameter int unsigned NDW_W = 5,
  parameter int unsigned NB_W  = 7
) (
  input  logic [FLASH_AW-3:0] dw_addr_i,
  input  logic [NDW_W-1:0]    ndw_i,
  input  logic [3:0]          be_i,
  output logic [FLASH_AW-1:0] start_o,
  output logic [NB_W-1:0]     nbytes_o,
  output logic                zero_o,
  output logic                illegal_o
);
  logic       contig, hi_tail;
  logic [1:0] low_lane;
  logic [NB_W-1:0] pop, full;

  always_comb begin
    contig  = be_i inside {4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011,
                           4'b0110, 4'b1100, 4'b0111, 4'b1110, 4'b1111};
    hi_tail = be_i inside {4'b1000, 4'b1100, 4'b1110, 4'b1111};
    if (be_i[0])      low_lane = 2'd0;
    else if (be_i[1]) low_lane = 2'd1;
    else if (be_i[2]) low_lane = 2'd2;
    else              low_lane = 2'd3;
    pop  = NB_W'(be_i[0]) + NB_W'(be_i[1]) + NB_W'(be_i[2]) + NB_W'(be_i[3]);
    full = NB_W'(ndw_i) * NB_W'(4);

    start_o   = {dw_addr_i, 2'b00};
    nbytes_o  = full;
    zero_o    = 1'b0;
    illegal_o = 1'b0;
    if (ndw_i == NDW_W'(1)) begin
      if (be_i == 4'b0000) begin
        zero_o   = 1'b1;
        nbytes_o = '0;
      end else if (contig) begin
        start_o  = {dw_addr_i, low_lane};
        nbytes_o = pop;
      end
    end else begin
      if (be_i == 4'b0000) begin
        illegal_o = 1'b1;
        nbytes_o  = '0;
      end else if (hi_tail) begin
        start_o  = {dw_addr_i, low_lane};
        nbytes_o = full - NB_W'(4) + pop;
      end
    end
  end
endmodule

// File: rtl/spi_dr_byte.sv
module spi_dr_byte #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [BITS-1:0] tx_i,
  output logic            done_o,
  output logic [BITS-1:0] rx_o,
  output logic            sck_o,
  output logic            mosi_o,
  input  logic            miso_i
);
  localparam int unsigned CNT_W = $clog2(2 * BITS);

  logic [CNT_W-1:0] cnt_q;
  logic [BITS-1:0]  sh_q;
  logic             busy_q, done_q;

  // even count: SCK low, MOSI settled; odd count: SCK high, sample at its end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        sh_q   <= tx_i;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q[0]) sh_q <= {sh_q[BITS-2:0], miso_i};
        if (cnt_q == CNT_W'(2 * BITS - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign sck_o  = busy_q & cnt_q[0];
  assign mosi_o = sh_q[BITS-1];
  assign rx_o   = sh_q;
  assign done_o = done_q;

  a_r8_no_restart_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  a_r8_mosi_hold_sck_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> $stable(mosi_o));
endmodule

// File: rtl/spi_flash_dread.sv
module spi_flash_dread
  import spi_dr_pkg::*;
#(
  parameter int unsigned MAX_DW = 16,
  localparam int unsigned NDW_W = $clog2(MAX_DW + 1),
  localparam int unsigned NB_W  = $clog2(4 * MAX_DW + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [FLASH_AW-3:0] req_dw_addr_i,
  input  logic [NDW_W-1:0]    req_ndw_i,
  input  logic [3:0]          req_first_be_i,
  output logic                rsp_valid_o,
  output logic [31:0]         rsp_data_o,
  output logic                rsp_last_o,
  output logic                rsp_err_o,
  output logic                spi_cs_no,
  output logic                spi_sck_o,
  output logic                spi_mosi_o,
  input  logic                spi_miso_i
);
  dr_state_e state_q;
  logic [FLASH_AW-1:0] plan_start, addr_q;
  logic [NB_W-1:0]     plan_nb, left_q;
  logic                plan_zero, plan_ill;
  logic                go_q, bdone;
  logic [7:0]          tx_q, rx;
  logic [1:0]          lane_q, idx_q;
  logic [31:0]         acc_q, acc_nx;
  logic                rsp_valid_q, rsp_last_q, rsp_err_q;
  logic [31:0]         rsp_data_q;

  spi_dr_plan #(.NDW_W(NDW_W), .NB_W(NB_W)) u_plan (
    .dw_addr_i (req_dw_addr_i),
    .ndw_i     (req_ndw_i),
    .be_i      (req_first_be_i),
    .start_o   (plan_start),
    .nbytes_o  (plan_nb),
    .zero_o    (plan_zero),
    .illegal_o (plan_ill)
  );

  spi_dr_byte #(.BITS(8)) u_byte (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (go_q),
    .tx_i    (tx_q),
    .done_o  (bdone),
    .rx_o    (rx),
    .sck_o   (spi_sck_o),
    .mosi_o  (spi_mosi_o),
    .miso_i  (spi_miso_i)
  );

  always_comb begin
    acc_nx = acc_q;
    acc_nx[{lane_q, 3'b000} +: 8] = rx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_POLL_GAP;
      go_q        <= 1'b0;
      tx_q        <= '0;
      addr_q      <= '0;
      left_q      <= '0;
      lane_q      <= '0;
      idx_q       <= '0;
      acc_q       <= '1;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '1;
      rsp_last_q  <= 1'b0;
      rsp_err_q   <= 1'b0;
    end else begin
      go_q        <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_last_q  <= 1'b0;
      rsp_err_q   <= 1'b0;
      unique case (state_q)
        ST_POLL_GAP: begin
          state_q <= ST_POLL_CMD;
          go_q    <= 1'b1;
          tx_q    <= OP_STATUS;
        end
        ST_POLL_CMD: if (bdone) begin
          state_q <= ST_POLL_RD;
          go_q    <= 1'b1;
          tx_q    <= 8'h00;
        end
        ST_POLL_RD: if (bdone) state_q <= rx[0] ? ST_POLL_GAP : ST_END;
        ST_IDLE: if (req_valid_i) begin
          if (plan_zero || plan_ill) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= '1;
            rsp_last_q  <= 1'b1;
            rsp_err_q   <= plan_ill;
          end else begin
            addr_q  <= plan_start;
            left_q  <= plan_nb;
            lane_q  <= plan_start[1:0];
            acc_q   <= '1;
            state_q <= ST_CMD;
            go_q    <= 1'b1;
            tx_q    <= OP_READ;
          end
        end
        ST_CMD: if (bdone) begin
          state_q <= ST_ADDR;
          idx_q   <= 2'd0;
          go_q    <= 1'b1;
          tx_q    <= addr_q[23:16];
        end
        ST_ADDR: if (bdone) begin
          go_q  <= 1'b1;
          idx_q <= idx_q + 2'd1;
          if (idx_q == 2'd0)      tx_q <= addr_q[15:8];
          else if (idx_q == 2'd1) tx_q <= addr_q[7:0];
          else begin
            tx_q    <= 8'h00;
            state_q <= ST_DATA;
          end
        end
        ST_DATA: if (bdone) begin
          left_q <= left_q - NB_W'(1);
          lane_q <= lane_q + 2'd1;
          if (lane_q == 2'd3 || left_q == NB_W'(1)) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= acc_nx;
            rsp_last_q  <= (left_q == NB_W'(1));
            acc_q       <= '1;
          end else begin
            acc_q <= acc_nx;
          end
          if (left_q == NB_W'(1)) state_q <= ST_END;
          else begin
            go_q <= 1'b1;
            tx_q <= 8'h00;
          end
        end
        ST_END:  state_q <= ST_IDLE;
        default: state_q <= ST_POLL_GAP;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign spi_cs_no   = (state_q == ST_POLL_GAP) || (state_q == ST_IDLE) || (state_q == ST_END);
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign rsp_last_o  = rsp_last_q;
  assign rsp_err_o   = rsp_err_q;

  a_r10_ready_cs_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> spi_cs_no);
  a_r2_zero_no_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && plan_zero) |=>
      (spi_cs_no && rsp_valid_o && rsp_last_o && !rsp_err_o && rsp_data_o == '1));
  a_r7_illegal_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && plan_ill) |=> (spi_cs_no && rsp_err_o && rsp_last_o));
  a_r9_err_only_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> rsp_last_o);
  a_r5_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !plan_zero && !plan_ill) |->
      (plan_nb != '0 && plan_nb <= NB_W'(req_ndw_i) * NB_W'(4)));
  a_r1_no_sck_cs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o);
endmodule

// File: tb/spi_flash_dread_tb_top.sv
`timescale 1ns/1ps
module spi_flash_dread_tb_top;
  localparam int MAX_DW = 16;
  localparam int NDW_W = 5;
  localparam int BUSY_POLLS = 3;
  localparam int NV = 12;
  // {dw_addr[21:0], ndw[4:0], be[3:0]}
  localparam logic [30:0] VEC [NV] = '{
    {22'h000100, 5'd1,  4'b0110},
    {22'h000101, 5'd1,  4'b1000},
    {22'h000102, 5'd1,  4'b1111},
    {22'h000103, 5'd1,  4'b0101},
    {22'h000104, 5'd1,  4'b1011},
    {22'h012340, 5'd3,  4'b1100},
    {22'h012341, 5'd2,  4'b1111},
    {22'h012342, 5'd4,  4'b0011},
    {22'h3FFFF0, 5'd2,  4'b0101},
    {22'h000200, 5'd16, 4'b1000},
    {22'h000300, 5'd1,  4'b0001},
    {22'h000310, 5'd5,  4'b1001}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 1'b0, req_ready;
  logic [21:0] req_dwa = '0;
  logic [NDW_W-1:0] req_ndw = NDW_W'(1);
  logic [3:0] req_be = '0;
  logic rsp_valid, rsp_last, rsp_err;
  logic [31:0] rsp_data;
  logic spi_cs_n, spi_sck, spi_mosi;
  logic miso = 1'b0;

  spi_flash_dread #(.MAX_DW(MAX_DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_dw_addr_i(req_dwa), .req_ndw_i(req_ndw), .req_first_be_i(req_be),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_last_o(rsp_last), .rsp_err_o(rsp_err),
    .spi_cs_no(spi_cs_n), .spi_sck_o(spi_sck), .spi_mosi_o(spi_mosi), .spi_miso_i(miso)
  );

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return 8'(a[7:0] * 8'd29) ^ a[15:8] ^ {a[23:20], 4'h5};
  endfunction

  // flash model
  int nbits = 0, polls = 0, reads = 0, frames = 0, last_n = 0;
  logic [31:0] sh_in = '0;
  logic [7:0] opcode = '0;
  logic [23:0] rd_addr = '0, last_addr = '0;

  always @(posedge spi_sck or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      if (nbits > 0) begin
        frames++;
        if (opcode == 8'h05) polls++;
        if (opcode == 8'h03) begin
          reads++;
          last_addr = rd_addr;
          last_n = (nbits - 32) / 8;
        end
      end
      nbits = 0;
      opcode = '0;
    end else begin
      sh_in = {sh_in[30:0], spi_mosi};
      nbits++;
      if (nbits == 8) opcode = sh_in[7:0];
      if (nbits == 32) rd_addr = sh_in[23:0];
    end
  end

  always @(negedge spi_sck) begin
    int k;
    logic [7:0] b;
    if (opcode == 8'h05 && nbits >= 8) begin
      k = nbits - 8;
      b = {6'd0, 1'b1, (polls < BUSY_POLLS)};
      miso = b[7 - (k % 8)];
    end else if (opcode == 8'h03 && nbits >= 32) begin
      k = nbits - 32;
      b = mem_byte(rd_addr + 24'(k / 8));
      miso = b[7 - (k % 8)];
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  logic [31:0] rd [MAX_DW];
  bit rl [MAX_DW];
  bit re [MAX_DW];
  int rcnt, rdy_hi;
  bit first_cs_low;

  // must be called at a falling edge
  task automatic issue(input logic [21:0] dwa, input int ndw, input logic [3:0] be);
    req_dwa = dwa;
    req_ndw = NDW_W'(ndw);
    req_be = be;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic collect();
    rcnt = 0;
    rdy_hi = 0;
    first_cs_low = 0;
    for (int t = 0; t < 5000; t++) begin
      if (rsp_valid) begin
        if (rcnt == 0) first_cs_low = !spi_cs_n;
        if (rcnt < MAX_DW) begin
          rd[rcnt] = rsp_data;
          rl[rcnt] = rsp_last;
          re[rcnt] = rsp_err;
        end
        rcnt++;
        if (rsp_last) break;
      end
      if (req_ready) rdy_hi++;
      @(negedge clk);
    end
  endtask

  task automatic expect_of(input logic [21:0] dwa, input int ndw, input logic [3:0] be,
                           output logic [23:0] st, output int n, output bit zero,
                           output bit ill, output string tag);
    int low, pop;
    low = be[0] ? 0 : be[1] ? 1 : be[2] ? 2 : 3;
    pop = int'(be[0]) + int'(be[1]) + int'(be[2]) + int'(be[3]);
    st = {dwa, 2'b00};
    n = 4 * ndw;
    zero = 0;
    ill = 0;
    if (ndw == 1) begin
      if (be == 4'b0000) begin zero = 1; n = 0; tag = "R2"; end
      else if (be inside {4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011,
                          4'b0110, 4'b1100, 4'b0111, 4'b1110, 4'b1111}) begin
        st = {dwa, 2'(low)}; n = pop; tag = "R3";
      end else tag = "R4";
    end else begin
      if (be == 4'b0000) begin ill = 1; n = 0; tag = "R7"; end
      else if (be inside {4'b1000, 4'b1100, 4'b1110, 4'b1111}) begin
        st = {dwa, 2'(low)}; n = 4 * (ndw - 1) + pop; tag = "R5";
      end else tag = "R6";
    end
  endtask

  task automatic verify(input logic [21:0] dwa, input int ndw, input logic [3:0] be,
                        input int reads0, input int frames0);
    logic [23:0] st, a;
    int n, d;
    bit zero, ill;
    string tag;
    logic [31:0] exp [MAX_DW];
    expect_of(dwa, ndw, be, st, n, zero, ill, tag);
    if (zero || ill) begin
      chk(rcnt == 1, {tag, " one completion"}, 32'(rcnt), 32'd1);
      chk(rd[0] == 32'hFFFFFFFF && rl[0], {tag, " data/last"}, rd[0], 32'hFFFFFFFF);
      chk(re[0] == ill, {tag, " error flag"}, 32'(re[0]), 32'(ill));
      chk(frames == frames0, {tag, " no SPI frame"}, 32'(frames), 32'(frames0));
      return;
    end
    for (int i = 0; i < MAX_DW; i++) exp[i] = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      a = st + 24'(i);
      d = int'(a[23:2]) - int'(st[23:2]);
      exp[d][{a[1:0], 3'b000} +: 8] = mem_byte(a);
    end
    chk(reads == reads0 + 1, "R8 one read frame", 32'(reads), 32'(reads0 + 1));
    chk(last_addr == st, {tag, " R8 start address"}, 32'(last_addr), 32'(st));
    chk(last_n == n, {tag, " byte count"}, 32'(last_n), 32'(n));
    chk(rcnt == ndw, "R9 completion count", 32'(rcnt), 32'(ndw));
    for (int i = 0; i < ndw && i < MAX_DW && i < rcnt; i++) begin
      chk(rd[i] == exp[i], {tag, " R9 data"}, rd[i], exp[i]);
      chk(rl[i] == (i == ndw - 1) && !re[i], "R9 last/err flags", {30'd0, re[i], rl[i]},
          {31'd0, (i == ndw - 1)});
    end
  endtask

  task automatic run(input logic [21:0] dwa, input int ndw, input logic [3:0] be);
    int r0, f0;
    r0 = reads;
    f0 = frames;
    issue(dwa, ndw, be);
    collect();
    verify(dwa, ndw, be, r0, f0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=%0d exp=done", n_chk);
    finish_run();
  end

  initial begin
    int r0, f0;
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1 cs high in reset", 32'(spi_cs_n), 32'd1);
    chk(!req_ready, "R1 ready low in reset", 32'(req_ready), 32'd0);
    chk(!rsp_valid, "R9 no completion in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R1 ready low while polling", 32'(req_ready), 32'd0);

    // R1: request presented during polling is held until status clears
    r0 = reads;
    f0 = frames;
    issue(22'h000050, 2, 4'b1111);
    chk(polls == BUSY_POLLS + 1, "R1 poll count before accept", 32'(polls), 32'(BUSY_POLLS + 1));
    chk(reads == 0, "R1 no read during polling", 32'(reads), 32'd0);
    collect();
    verify(22'h000050, 2, 4'b1111, r0, f0);

    for (int v = 0; v < NV; v++) run(VEC[v][30:9], int'(VEC[v][8:4]), VEC[v][3:0]);

    run(22'h000400, 1, 4'b0000);  // R2
    run(22'h000401, 3, 4'b0000);  // R7
    chk(polls == BUSY_POLLS + 1, "R1 no polling after ready", 32'(polls), 32'(BUSY_POLLS + 1));

    // R10: second request held while the first runs; R9 early completion
    r0 = reads;
    f0 = frames;
    issue(22'h000500, 4, 4'b1111);
    req_dwa = 22'h000600;
    req_ndw = NDW_W'(2);
    req_be = 4'b0110;
    req_valid = 1'b1;
    collect();
    chk(rdy_hi == 0, "R10 ready low during transfer", 32'(rdy_hi), 32'd0);
    chk(first_cs_low, "R9 first DWord before frame end", 32'(first_cs_low), 32'd1);
    verify(22'h000500, 4, 4'b1111, r0, f0);
    r0 = reads;
    f0 = frames;
    issue(22'h000600, 2, 4'b0110);
    collect();
    verify(22'h000600, 2, 4'b0110, r0, f0);

    finish_run();
  end
endmodule